// File: doc/BRIEF.md
# Status Report Packet Sender

This block turns a parallel status word into a short packet of bytes on a shared 8-bit status bus. When a report is due it raises a request and presents a header byte holding a fixed status register address. The downstream side answers with a one-cycle start pulse. The payload bytes then follow back to back, one per clock. The first payload byte packs a 6-bit sequence number above the two lowest status bits. The bytes after it carry the remaining status bits, eight at a time. The payload width is a parameter between 15 and 26 bits, and it sets the packet length.

A control byte, written through a write strobe, chooses the reporting mode and loads the sequence number. In single-shot mode exactly one report is sent after the write. In automatic mode a report is sent after the write and again whenever the status input differs from the last value sent. The status word and the sequence number are captured when start is accepted, so every byte of one packet describes the same moment. Arbitration between several such senders, and the origin of the status bits, belong to the surrounding logic.

Top module: `stat_pkt_gen`

## Requirements
- R1: After synchronous reset, `statRq` is 0, `statAd` is 0, the mode is off and the sequence number is 0.
- R2: A write with `ctlWe` high loads the mode from `ctlData[7:6]` and the sequence number from `ctlData[5:0]`. The mode codes are 0 off, 1 single report, 2 automatic and 3 automatic.
- R3: After a write that selects mode 1, 2 or 3 while no packet is in progress, `statRq` rises after the second rising edge counted from the write edge.
- R4: `statRq` stays high until `statStart` is sampled high. `statStart` has no effect while `statRq` is low.
- R5: While `statRq` is high, `statAd` equals the parameter `STAT_ADDR`. The packet is 2 + ceil((PAYLOAD_W-2)/8) bytes long. Counting from the cycle after acceptance, the payload bytes on consecutive cycles are: {seq[5:0], status[1:0]}, then status[9:2], then status[17:10], then status[25:18], for as many bytes as the payload width needs.
- R6: The status word and the sequence number are captured at the edge where start is accepted. Later changes of `status` do not alter the bytes of that packet.
- R7: Each accepted packet increments the sequence number modulo 64. If a control write falls in the same cycle as acceptance, the written value wins and the packet carries the old number.
- R8: In automatic mode a new request is raised when `status` differs from the last value sent. No request is raised while it is equal.
- R9: In mode off, status changes raise no request. In mode 1, only one packet is sent per write.
- R10: `statRq` is low while payload bytes are being sent. `statAd` is 0 when neither a request nor a packet is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ctlWe | input | 1 | Control byte write strobe |
| ctlData | input | 8 | Control byte: [7:6] mode, [5:0] sequence number |
| status | input | PAYLOAD_W | Parallel status word to report |
| statAd | output | 8 | Status bus byte: header or payload |
| statRq | output | 1 | Request to send a packet |
| statStart | input | 1 | Acknowledge of the header byte |

## Verification
The control write and the acceptance of a request by `statStart` can land on the same clock edge. Both of them update the sequence number and the report arming. The bench forces this collision directly while a request is pending in automatic mode, and random traffic also produces it. It is judged by two facts: the first payload byte of the packet in flight must carry the old sequence number, and the packet that follows must carry the newly written number, because the write re-arms a report.

// File: rtl/stat_pkt_pkg.sv
package stat_pkt_pkg;
  localparam int MAX_PKT_BYTES = 5;
  localparam int IDX_W = 3;
  localparam int SEQ_W = 6;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_ONCE   = 2'd1,
    MODE_AUTO   = 2'd2,
    MODE_AUTO_R = 2'd3
  } mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             accept;
    logic             busy;
    logic             rqOn;
    logic [IDX_W-1:0] idx;
  } strb_t;

  function automatic int pktBytes(input int payloadW);
    return 2 + (payloadW - 2 + 7) / 8;
  endfunction
endpackage

// File: rtl/stat_pkt_ctrl.sv
module stat_pkt_ctrl
  import stat_pkt_pkg::*;
#(
  parameter int PAYLOAD_W = 26
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctlWe,
  input  logic [7:0]       ctlData,
  input  logic             statStart,
  input  logic             changed,
  output logic             statRq,
  output strb_t            strb,
  output logic [SEQ_W-1:0] seq
);
  localparam int NB = pktBytes(PAYLOAD_W);

  mode_e            mode;
  logic             armed;
  logic             rqReg;
  logic [IDX_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic             accept;
  logic             busy;
  logic             due;

  assign busy   = cnt != '0;
  assign accept = rqReg && statStart;
  assign due    = (mode != MODE_OFF) && (armed || (mode[1] && changed));

  always_ff @(posedge clk) begin
    if (rst) begin
      mode  <= MODE_OFF;
      armed <= 1'b0;
      rqReg <= 1'b0;
      cnt   <= '0;
      idx   <= '0;
      seq   <= '0;
    end else begin
      if (ctlWe) begin
        mode  <= mode_e'(ctlData[7:6]);
        seq   <= ctlData[SEQ_W-1:0];
        armed <= ctlData[7:6] != 2'd0;
      end else if (accept) begin
        seq   <= seq + 1'b1;
        armed <= 1'b0;
      end

      if (accept)                        rqReg <= 1'b0;
      else if (!rqReg && !busy && due)   rqReg <= 1'b1;

      if (accept) begin
        cnt <= IDX_W'(NB - 1);
        idx <= IDX_W'(1);
      end else if (busy) begin
        cnt <= cnt - 1'b1;
        idx <= idx + 1'b1;
      end
    end
  end

  assign statRq      = rqReg;
  assign strb.accept = accept;
  assign strb.busy   = busy;
  assign strb.rqOn   = rqReg;
  assign strb.idx    = idx;
endmodule

// File: rtl/stat_pkt_dp.sv
module stat_pkt_dp
  import stat_pkt_pkg::*;
#(
  parameter logic [7:0] STAT_ADDR = 8'h3C,
  parameter int         PAYLOAD_W = 26
) (
  input  logic                 clk,
  input  logic                 rst,
  input  strb_t                strb,
  input  logic [SEQ_W-1:0]     seq,
  input  logic [PAYLOAD_W-1:0] status,
  output logic                 changed,
  output logic [7:0]           statAd
);
  localparam int PAD_W = 8 * (MAX_PKT_BYTES - 2) + 2;

  logic [PAYLOAD_W-1:0]       sentStat;
  logic [SEQ_W-1:0]           seqHeld;
  logic [PAD_W-1:0]           padded;
  logic [8*MAX_PKT_BYTES-1:0] pktFlat;

  always_ff @(posedge clk) begin
    if (rst) begin
      sentStat <= '0;
      seqHeld  <= '0;
    end else if (strb.accept) begin
      sentStat <= status;
      seqHeld  <= seq;
    end
  end

  assign changed = status != sentStat;
  assign padded  = PAD_W'(sentStat);

  assign pktFlat[7:0]  = STAT_ADDR;
  assign pktFlat[15:8] = {seqHeld, padded[1:0]};
  for (genvar k = 2; k < MAX_PKT_BYTES; k++) begin : g_byte
    assign pktFlat[8*k +: 8] = padded[8*k-7 -: 8];
  end

  always_comb begin
    if (strb.busy)      statAd = pktFlat[int'(strb.idx)*8 +: 8];
    else if (strb.rqOn) statAd = STAT_ADDR;
    else                statAd = 8'h00;
  end
endmodule

// File: rtl/stat_pkt_gen.sv
module stat_pkt_gen
  import stat_pkt_pkg::*;
#(
  parameter logic [7:0] STAT_ADDR = 8'h3C,
  parameter int         PAYLOAD_W = 26
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ctlWe,
  input  logic [7:0]           ctlData,
  input  logic [PAYLOAD_W-1:0] status,
  output logic [7:0]           statAd,
  output logic                 statRq,
  input  logic                 statStart
);
  strb_t            strb;
  logic [SEQ_W-1:0] seq;
  logic             changed;

  stat_pkt_ctrl #(.PAYLOAD_W(PAYLOAD_W)) u_ctrl (
    .clk(clk), .rst(rst), .ctlWe(ctlWe), .ctlData(ctlData),
    .statStart(statStart), .changed(changed),
    .statRq(statRq), .strb(strb), .seq(seq)
  );

  stat_pkt_dp #(.STAT_ADDR(STAT_ADDR), .PAYLOAD_W(PAYLOAD_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .seq(seq), .status(status),
    .changed(changed), .statAd(statAd)
  );
endmodule

// File: rtl/stat_pkt_chk.sv
module stat_pkt_chk #(
  parameter logic [7:0] STAT_ADDR = 8'h3C,
  parameter int         PAYLOAD_W = 26
) (
  input logic                 clk,
  input logic                 rst,
  input logic [PAYLOAD_W-1:0] status,
  input logic [7:0]           statAd,
  input logic                 statRq,
  input logic                 statStart
);
  // R4
  rq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    statRq && !statStart |=> statRq);

  // R10
  rq_drop_chk: assert property (@(posedge clk) disable iff (rst)
    statRq && statStart |=> !statRq);

  // R5
  hdr_byte_chk: assert property (@(posedge clk) disable iff (rst)
    statRq |-> statAd == STAT_ADDR);

  // R6
  low_bits_chk: assert property (@(posedge clk) disable iff (rst)
    statRq && statStart |=> statAd[1:0] == $past(status[1:0]));
endmodule

bind stat_pkt_gen stat_pkt_chk #(.STAT_ADDR(STAT_ADDR), .PAYLOAD_W(PAYLOAD_W)) u_chk (
  .clk(clk), .rst(rst), .status(status), .statAd(statAd),
  .statRq(statRq), .statStart(statStart)
);

// File: tb/test_stat_pkt_gen.sv
module test_stat_pkt_gen;
  localparam logic [7:0] ADDR = 8'h3C;
  localparam int W  = 26;
  localparam int NB = 2 + (W - 2 + 7) / 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ctlWe = 1'b0;
  logic [7:0]   ctlData = 8'h00;
  logic [W-1:0] status = '0;
  logic         statStart = 1'b0;
  logic [7:0]   statAd;
  logic         statRq;

  int nChk = 0;
  int nBad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  stat_pkt_gen #(.STAT_ADDR(ADDR), .PAYLOAD_W(W)) i_stat_pkt_gen (
    .clk(clk), .rst(rst), .ctlWe(ctlWe), .ctlData(ctlData), .status(status),
    .statAd(statAd), .statRq(statRq), .statStart(statStart)
  );

  // reference model built from the requirements
  logic [1:0]   mMode;
  logic [5:0]   mSeq, mSeqL;
  logic         mArmed, mRq;
  int           mCnt, mIdx;
  logic [W-1:0] mSent;

  function automatic logic [7:0] payByte(input logic [25:0] s, input logic [5:0] q, input int k);
    if (k == 1) return {q, s[1:0]};
    return s[8*k-7 -: 8];
  endfunction

  function automatic logic [7:0] expAd();
    if (mCnt != 0) return payByte(26'(mSent), mSeqL, mIdx);
    if (mRq) return ADDR;
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mMode <= 0; mSeq <= 0; mSeqL <= 0; mArmed <= 0; mRq <= 0;
      mCnt <= 0; mIdx <= 0; mSent <= '0;
    end else begin
      automatic bit acc = mRq && statStart;
      automatic bit due = (mMode != 0) && (mArmed || (mMode >= 2 && status != mSent));
      if (ctlWe) begin
        mMode <= ctlData[7:6]; mSeq <= ctlData[5:0]; mArmed <= ctlData[7:6] != 0;
      end else if (acc) begin
        mSeq <= mSeq + 6'd1; mArmed <= 0;
      end
      if (acc) mRq <= 0;
      else if (!mRq && mCnt == 0 && due) mRq <= 1;
      if (acc) begin
        mCnt <= NB - 1; mIdx <= 1; mSent <= status; mSeqL <= mSeq;
      end else if (mCnt != 0) begin
        mCnt <= mCnt - 1; mIdx <= mIdx + 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // one clock, then compare both outputs with the model
  task automatic step();
    @(negedge clk);
    chk("R4 statRq vs model", 32'(statRq), 32'(mRq));
    chk("R5 statAd vs model", 32'(statAd), 32'(expAd()));
  endtask

  task automatic wrCtl(input logic [1:0] m, input logic [5:0] q);
    ctlWe = 1; ctlData = {m, q};
    step();
    ctlWe = 0;
  endtask

  task automatic drainBytes(input logic [25:0] s);
    for (int k = 2; k < NB; k++) begin
      step();
      chk($sformatf("R5 byte %0d", k), 32'(statAd), 32'(payByte(s, 0, k)));
      chk("R10 no rq in packet", 32'(statRq), 0);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end

  initial begin
    logic [25:0] s1, s2, s3;
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    chk("R1 rq after reset", 32'(statRq), 0);
    chk("R1 ad after reset", 32'(statAd), 0);

    // R9 off mode ignores status
    status = 26'h1234567; step(); step();
    chk("R9 off mode no rq", 32'(statRq), 0);
    status = 26'h0ABCDEF; step(); step();
    chk("R9 off mode no rq 2", 32'(statRq), 0);
    chk("R10 idle ad zero", 32'(statAd), 0);

    // R2 R3 single report
    wrCtl(2'd1, 6'd5);
    chk("R3 rq not yet", 32'(statRq), 0);
    step();
    chk("R3 rq raised", 32'(statRq), 1);
    chk("R5 header", 32'(statAd), 32'(ADDR));
    step(); step();
    chk("R4 rq held", 32'(statRq), 1);
    s1 = 26'h2D5A3C7; status = s1; statStart = 1;
    step();
    statStart = 0; status = 26'h3FFFFFF;
    chk("R2 R6 byte1 seq and low bits", 32'(statAd), 32'({6'd5, s1[1:0]}));
    chk("R10 rq dropped", 32'(statRq), 0);
    drainBytes(s1);
    step();
    chk("R10 ad zero after packet", 32'(statAd), 0);
    step(); step(); step();
    chk("R9 single report only once", 32'(statRq), 0);

    // R4 start ignored without request
    statStart = 1; step(); step();
    chk("R4 start ignored rq", 32'(statRq), 0);
    chk("R4 start ignored ad", 32'(statAd), 0);
    statStart = 0;

    // R7 R8 auto with wrap
    wrCtl(2'd2, 6'd63);
    step();
    chk("R8 auto initial rq", 32'(statRq), 1);
    s2 = 26'(status); statStart = 1; step(); statStart = 0;
    chk("R7 seq 63", 32'(statAd), 32'({6'd63, s2[1:0]}));
    s3 = 26'h0123456; status = s3;
    drainBytes(s2);
    step();
    chk("R10 gap", 32'(statRq), 0);
    step();
    chk("R8 change raises rq", 32'(statRq), 1);
    statStart = 1; step(); statStart = 0;
    chk("R7 seq wraps to 0", 32'(statAd), 32'({6'd0, s3[1:0]}));
    drainBytes(s3);
    step(); step(); step();
    chk("R8 unchanged no rq", 32'(statRq), 0);

    // R7 collision of write and acceptance
    status = 26'h155AA33; s1 = 26'h155AA33;
    step();
    chk("R8 rq on change", 32'(statRq), 1);
    statStart = 1; ctlWe = 1; ctlData = {2'd2, 6'd20};
    step();
    statStart = 0; ctlWe = 0;
    chk("R7 collision old seq", 32'(statAd), 32'({6'd1, s1[1:0]}));
    drainBytes(s1);
    step(); step();
    chk("R7 rearmed by write", 32'(statRq), 1);
    statStart = 1; step(); statStart = 0;
    chk("R7 written seq used", 32'(statAd), 32'({6'd20, s1[1:0]}));
    drainBytes(s1);

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      ctlWe = ($urandom % 20) == 0;
      ctlData = 8'($urandom);
      if (($urandom % 6) == 0) status = status ^ W'($urandom);
      statStart = ($urandom % 3) == 0;
      step();
    end
    ctlWe = 0; statStart = 0;
    step();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule